// File: doc/BRIEF.md
# Cache Slice Event Counter Bank

This block holds four 32-bit event counters for one slice of a last-level cache. Software reaches them over a simple register bus. Each counter has two words: a control word and a count word. A nonzero control word arms its counter. Bits [7:3] of that word choose one line of the event strobe vector. While armed, the counter adds one on every clock in which the chosen strobe is high.

Writing zero to the control word stops the counter. Writing to the count word loads it, and writing zero clears it. Counters wrap through zero without any signal, so software takes differences modulo 2^32. Selector values of 0x18 and above name no event and never count.

The bus is byte addressed. The two words of each counter sit side by side. Reads come back registered, one cycle after the request, and any offset outside the map reads as zero.

Top module: `llc_event_bank`

## Requirements
- R1: After a synchronous reset, every control word, every count and the read data output are zero.
- R2: Counter n (n = 0..3) has its control word at byte offset 0xA8 + 8*n and its count word at 0xAC + 8*n. An address whose bits [1:0] are not zero does not select any register.
- R3: A write to a control word stores all 32 bits, and a read returns that stored word. Only bits [7:3] form the event selector.
- R4: A counter whose control word is nonzero, with a selector below 0x18, adds exactly one on each clock edge at which the strobe bit numbered by its selector is high.
- R5: A counter whose control word is zero holds its count whatever the strobes do.
- R6: A selector of 0x18 or above never counts, even when every strobe is high and the control word is nonzero.
- R7: A write to a count word loads the written value, and writing zero clears it. In the same cycle, the write wins over an increment.
- R8: A count of 0xFFFFFFFF followed by one more event becomes 0x00000000.
- R9: Read data appears on the clock edge that samples the read request. It shows the register contents from before that edge, and it holds until the next read.
- R10: A read of an unmapped or misaligned offset returns zero. A write to such an offset changes no register.
- R11: Each counter follows only its own selector. Two counters on the same event both count it, and a counter on another event does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write request for this cycle |
| bus_rd | input | 1 | Read request for this cycle |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_strobe | input | 24 | Event strobes, one bit per event code |

## Verification
Every result is due exactly one clock edge after its stimulus:
- a write is in the register after the edge that samples it;
- a strobe held high across k edges adds k;
- read data is valid after the edge that samples the read request.

The bench drives all inputs on the falling edge and holds each for whole cycles. It reads outputs on the next falling edge, so every check samples half a cycle after the edge that produced the result. For the write-versus-event case, both are driven in the same cycle, and the count is then read back through the bus.

// File: rtl/llc_evb_pkg.sv
package llc_evb_pkg;
  // register map layout: control word, then count word, per counter
  localparam int unsigned EVB_BASE     = 'hA8;
  localparam int unsigned EVB_STRIDE   = 8;
  localparam int unsigned EVB_DATA_OFS = 4;
  localparam int unsigned EVB_IDX_LSB  = 3;
  // selector field inside the control word
  localparam int unsigned EVB_SEL_LSB  = 3;
  localparam int unsigned EVB_SEL_W    = 5;
endpackage

// File: rtl/llc_evb_decode.sv
module llc_evb_decode
  import llc_evb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NUM_CNT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CNT-1:0] ctrl_hit,
  output logic [NUM_CNT-1:0] data_hit
);
  localparam int unsigned IDX_W   = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam int unsigned SPAN    = NUM_CNT * EVB_STRIDE;

  logic [ADDR_W-1:0] off;
  logic              in_map;
  logic [IDX_W-1:0]  idx;
  logic              is_data;

  always_comb begin
    off     = addr - ADDR_W'(EVB_BASE);
    in_map  = (addr >= ADDR_W'(EVB_BASE)) && (off < ADDR_W'(SPAN)) &&
              (addr[1:0] == 2'b00);
    idx     = off[EVB_IDX_LSB +: IDX_W];
    is_data = off[2];
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_sel
    assign ctrl_hit[g] = in_map && !is_data && (idx == IDX_W'(g));
    assign data_hit[g] = in_map &&  is_data && (idx == IDX_W'(g));
  end

  // R2: an address selects at most one register
  assert_single_select_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl_hit, data_hit}));
endmodule

// File: rtl/llc_evb_counter.sv
module llc_evb_counter
  import llc_evb_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_EVT = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctrl_we,
  input  logic               data_we,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_EVT-1:0] strobe,
  output logic [DATA_W-1:0]  ctrl_q,
  output logic [DATA_W-1:0]  cnt_q
);
  localparam int unsigned SEL_SPAN = 1 << EVB_SEL_W;

  logic [EVB_SEL_W-1:0] sel;
  logic [SEL_SPAN-1:0]  strobe_pad;
  logic                 armed;
  logic                 sel_ok;
  logic                 bump;

  always_comb begin
    strobe_pad              = '0;
    strobe_pad[NUM_EVT-1:0] = strobe;
    sel    = ctrl_q[EVB_SEL_LSB +: EVB_SEL_W];
    armed  = (ctrl_q != '0);
    sel_ok = (int'(sel) < NUM_EVT);
    bump   = armed && sel_ok && strobe_pad[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (data_we) begin
      cnt_q <= wdata;
    end else if (bump) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7: a count write lands regardless of a same-cycle event
  assert_write_load_R7: assert property (@(posedge clk) disable iff (rst)
    data_we |=> (cnt_q == $past(wdata)));
  // R5: a disarmed counter holds its count
  assert_disarmed_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!data_we && !ctrl_we && ctrl_q == '0) |=> $stable(cnt_q));
  // R6: a selector past the event range never counts
  assert_bad_sel_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!data_we && !sel_ok) |=> $stable(cnt_q));
  // R4: a selected strobe adds exactly one
  assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
    (!data_we && armed && sel_ok && strobe_pad[sel]) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/llc_evb_rdmux.sv
module llc_evb_rdmux #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_CNT = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rd_en,
  input  logic [NUM_CNT-1:0]             ctrl_hit,
  input  logic [NUM_CNT-1:0]             data_hit,
  input  logic [NUM_CNT-1:0][DATA_W-1:0] ctrl_words,
  input  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_words,
  output logic [DATA_W-1:0]              rdata
);
  logic [DATA_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (ctrl_hit[i]) pick = pick | ctrl_words[i];
      if (data_hit[i]) pick = pick | cnt_words[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= pick;
    end
  end

  // R10: a read outside the map returns zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && ctrl_hit == '0 && data_hit == '0) |=> (rdata == '0));
  // R9: read data holds between reads
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/llc_event_bank.sv
module llc_event_bank #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_CNT = 4,
  parameter int unsigned NUM_EVT = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_EVT-1:0] evt_strobe
);
  logic [NUM_CNT-1:0]             ctrl_hit;
  logic [NUM_CNT-1:0]             data_hit;
  logic [NUM_CNT-1:0][DATA_W-1:0] ctrl_words;
  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_words;

  llc_evb_decode #(
    .ADDR_W (ADDR_W),
    .NUM_CNT(NUM_CNT)
  ) u_dec (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .ctrl_hit(ctrl_hit),
    .data_hit(data_hit)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    llc_evb_counter #(
      .DATA_W (DATA_W),
      .NUM_EVT(NUM_EVT)
    ) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .ctrl_we(bus_wr && ctrl_hit[g]),
      .data_we(bus_wr && data_hit[g]),
      .wdata  (bus_wdata),
      .strobe (evt_strobe),
      .ctrl_q (ctrl_words[g]),
      .cnt_q  (cnt_words[g])
    );
  end

  llc_evb_rdmux #(
    .DATA_W (DATA_W),
    .NUM_CNT(NUM_CNT)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (bus_rd),
    .ctrl_hit  (ctrl_hit),
    .data_hit  (data_hit),
    .ctrl_words(ctrl_words),
    .cnt_words (cnt_words),
    .rdata     (bus_rdata)
  );
endmodule

// File: tb/sim_llc_event_bank.sv
module sim_llc_event_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [23:0] evt_strobe = '0;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  llc_event_bank u0 (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_strobe(evt_strobe)
  );

  function automatic logic [11:0] ctl_a(int n);
    return 12'(32'hA8 + 8 * n);
  endfunction
  function automatic logic [11:0] dat_a(int n);
    return 12'(32'hAC + 8 * n);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(logic [23:0] pattern, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evt_strobe = pattern;
    end
    @(negedge clk);
    evt_strobe = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 rdata after reset", bus_rdata, 32'h0);
    for (int n = 0; n < 4; n++) begin
      bus_read(ctl_a(n), v); check("R1 ctrl after reset", v, 32'h0);
      bus_read(dat_a(n), v); check("R1 count after reset", v, 32'h0);
    end
  endtask

  task automatic t_basic_count();
    logic [31:0] v;
    bus_write(ctl_a(0), 32'h0D << 3);
    bus_write(dat_a(0), 32'h0);
    pulse(24'h1 << 13, 5);
    bus_read(dat_a(0), v); check("R4 count event 0x0D", v, 32'd5);
    pulse(24'h1 << 14, 3);
    bus_read(dat_a(0), v); check("R11 other event ignored", v, 32'd5);
  endtask

  task automatic t_ctrl_readback();
    logic [31:0] v;
    bus_write(ctl_a(1), 32'hFFFF_FF70);
    bus_read(ctl_a(1), v); check("R3 ctrl full readback", v, 32'hFFFF_FF70);
    bus_write(dat_a(1), 32'h0);
    pulse(24'h1 << 14, 4);
    bus_read(dat_a(1), v); check("R3 selector from bits 7:3", v, 32'd4);
  endtask

  task automatic t_disarm();
    logic [31:0] v;
    bus_write(ctl_a(1), 32'h0);
    pulse(24'hFF_FFFF, 6);
    bus_read(dat_a(1), v); check("R5 disarmed holds", v, 32'd4);
  endtask

  task automatic t_bad_sel();
    logic [31:0] v;
    bus_write(ctl_a(2), 32'h18 << 3);
    bus_write(dat_a(2), 32'h55);
    pulse(24'hFF_FFFF, 4);
    bus_read(dat_a(2), v); check("R6 selector 0x18 idle", v, 32'h55);
    bus_write(ctl_a(2), 32'h1F << 3);
    pulse(24'hFF_FFFF, 4);
    bus_read(dat_a(2), v); check("R6 selector 0x1F idle", v, 32'h55);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = dat_a(0); bus_wdata = 32'h100;
    evt_strobe = 24'h1 << 13;
    @(negedge clk);
    bus_wr = 1'b0; evt_strobe = '0;
    bus_read(dat_a(0), v); check("R7 write beats increment", v, 32'h100);
    bus_write(dat_a(0), 32'h0);
    bus_read(dat_a(0), v); check("R7 write zero clears", v, 32'h0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    bus_write(dat_a(0), 32'hFFFF_FFFE);
    pulse(24'h1 << 13, 3);
    bus_read(dat_a(0), v); check("R8 wrap through zero", v, 32'h1);
  endtask

  task automatic t_read_timing();
    logic [31:0] v;
    bus_write(dat_a(3), 32'hABCD);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = dat_a(3);
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = ctl_a(0);
    check("R9 data one edge after request", bus_rdata, 32'hABCD);
    bus_write(dat_a(3), 32'h1234);
    repeat (2) @(negedge clk);
    check("R9 rdata holds between reads", bus_rdata, 32'hABCD);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    bus_read(12'h0A4, v); check("R10 below map reads zero", v, 32'h0);
    bus_read(12'h0C8, v); check("R10 above map reads zero", v, 32'h0);
    bus_read(12'h0AD, v); check("R2 misaligned reads zero", v, 32'h0);
    bus_write(12'h0A9, 32'hDEAD_BEEF);
    bus_write(12'h0C8, 32'hDEAD_BEEF);
    bus_read(ctl_a(0), v); check("R10 stray write left ctrl", v, 32'h0D << 3);
    bus_read(dat_a(3), v); check("R10 stray write left count", v, 32'h1234);
  endtask

  task automatic t_independent();
    logic [31:0] v;
    bus_write(ctl_a(1), 32'h14 << 3);
    bus_write(ctl_a(2), 32'h14 << 3);
    bus_write(ctl_a(3), 32'h17 << 3);
    bus_write(dat_a(1), 32'h0);
    bus_write(dat_a(2), 32'h0);
    bus_write(dat_a(3), 32'h0);
    pulse(24'h1 << 20, 3);
    pulse(24'h1 << 23, 2);
    bus_read(dat_a(1), v); check("R11 counter1 shared event", v, 32'd3);
    bus_read(dat_a(2), v); check("R11 counter2 shared event", v, 32'd3);
    bus_read(dat_a(3), v); check("R11 counter3 own event", v, 32'd2);
    bus_read(ctl_a(3), v); check("R2 ctrl3 at 0xC0", v, 32'h17 << 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic_count();
    t_ctrl_readback();
    t_disarm();
    t_bad_sel();
    t_priority();
    t_wrap();
    t_read_timing();
    t_unmapped();
    t_independent();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule